// File: doc/BRIEF.md
# Ethernet MAC Control and Status Register Bank

This block is the software-visible register file of a small 10/100 Ethernet MAC. It sits on a simple word-addressed bus: a write strobe, a read strobe, a word address and 32-bit write data. Read data comes back one cycle after the read strobe. The datapath and the management engine are not part of it. They send it one-cycle event pulses, and it sends back control fields, ring base addresses, the station address, the multicast filter, a management command word with a start strobe, and one level-sensitive interrupt line.

Event pulses set sticky status flags. Software clears a flag by writing a one to its position. Status bit 31 is a command rather than a flag: writing a one there sends a single-cycle demand-poll strobe to the transmit descriptor engine, and nothing is stored. Receive-side error events advance wrapping counters. Each wrap raises its own status flag, so software can extend the counters in firmware.

Top module: `emac_csr_bank`

## Requirements
- R1: The bus word addresses are 0 identification, 1 status, 2 interrupt enable, 3 control, 4 poll rate, 5 receive error counters, 6 missed-packet counter, 7 transmit ring base, 8 receive ring base, 9 station address low, 10 station address high, 11 filter low, 12 filter high and 13 management. Address 0 always reads the parameter ID_CODE (default 0x0005FD02), and writes to it are ignored.
- R2: A read strobe in one cycle gives bus_rvalid and bus_rdata in the following cycle. bus_rdata holds the register value as it stood before any write in the same cycle.
- R3: The control word keeps bits 31:24 (receive ring length), 23:16 (transmit ring length), 11 (promiscuous), 10 (full duplex), 8 (reject broadcast), 4 (receive enable), 3 (transmit enable) and 0 (global enable). Every other bit reads 0. Each field drives its output port.
- R4: Status flags sit at bit 0 (transmit done), bit 1 (receive done), bit 2 (error), bit 3 (transmit chaining error), bit 4 (missed counter wrap), bit 8 (CRC counter wrap), bit 9 (framing counter wrap), bit 10 (overflow counter wrap) and bit 12 (management complete). An event pulse sets its flag in the next cycle.
- R5: Writing a one to a status flag position clears that flag. Writing a zero leaves it unchanged.
- R6: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: Writing a one to status bit 31 makes poll_strobe high for exactly the next cycle. Status bit 31 always reads 0.
- R8: irq is high whenever some status flag in bits 12:0 is set and its bit in the interrupt-enable register is set. irq is low otherwise.
- R9: Address 5 packs three 8-bit counters: CRC errors in bits 7:0, framing errors in 15:8, overflow errors in 23:16. Each counts its event pulses, wraps from 255 to 0, and sets status bit 8, 9 or 10 on the wrap.
- R10: Address 6 is a 16-bit count of missed-packet pulses. It wraps from 65535 to 0 and sets status bit 4 on the wrap.
- R11: Writes to the counter addresses 5 and 6 are ignored.
- R12: The station address low word holds address bytes 0 to 3, with byte 0 in bits 7:0. The high word holds bytes 4 and 5 in its bits 15:0, and its other bits read 0. station_addr[47:0] presents byte 0 in bits 7:0.
- R13: A write to address 13 stores the word, drives it on mgmt_cmd and pulses mgmt_go for one cycle. A management-complete pulse loads mgmt_rd_data into bits 15:0 and sets status bit 12.
- R14: Poll rate, both ring bases and both filter words are full 32-bit read/write registers. They drive poll_rate, tx_ring_base, rx_ring_base and mcast_filter (with the low word in bits 31:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| bus_rvalid | output | 1 | Read data valid |
| ev_tx_done | input | 1 | Transmit done pulse |
| ev_rx_done | input | 1 | Receive done pulse |
| ev_err | input | 1 | General error pulse |
| ev_tx_chain | input | 1 | Transmit chaining error pulse |
| ev_crc_err | input | 1 | CRC error pulse |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_ovf_err | input | 1 | Receive overflow pulse |
| ev_missed | input | 1 | Missed packet pulse |
| ev_mgmt_done | input | 1 | Management transaction complete pulse |
| mgmt_rd_data | input | 16 | Management read result, taken with ev_mgmt_done |
| irq | output | 1 | Interrupt request |
| poll_strobe | output | 1 | Transmit demand-poll strobe |
| mac_en | output | 1 | Global enable |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| bcast_reject | output | 1 | Reject broadcast frames |
| full_duplex | output | 1 | Full-duplex select |
| promisc | output | 1 | Promiscuous mode |
| rx_ring_len | output | 8 | Receive ring length |
| tx_ring_len | output | 8 | Transmit ring length |
| poll_rate | output | 32 | Descriptor poll interval |
| tx_ring_base | output | 32 | Transmit ring base address |
| rx_ring_base | output | 32 | Receive ring base address |
| station_addr | output | 48 | Station address, byte 0 in bits 7:0 |
| mcast_filter | output | 64 | Multicast hash filter |
| mgmt_cmd | output | 32 | Management command word |
| mgmt_go | output | 1 | Management start strobe |

## Verification
A datapath event can arrive in the same cycle as a software write that clears that event's status flag. The bench provokes this by raising the receive-done pulse in the very cycle that a one is written to status bit 1. It then judges the result by reading status back and expecting the flag still set. A separate clearing write that follows must then remove the flag. The bench also checks that a counter wrap sets its flag in the same cycle the counter returns to zero. It does this by reading both the counter and status after the final pulse.

// File: rtl/emac_csr_pkg.sv
`timescale 1ns/1ps
package emac_csr_pkg;
  localparam int NREG   = 14;
  localparam int STAT_W = 13;

  typedef enum logic [3:0] {
    A_IDENT   = 4'd0,
    A_STAT    = 4'd1,
    A_IEN     = 4'd2,
    A_CTRL    = 4'd3,
    A_POLL    = 4'd4,
    A_ERRCNT  = 4'd5,
    A_MISSCNT = 4'd6,
    A_TXBASE  = 4'd7,
    A_RXBASE  = 4'd8,
    A_STA_LO  = 4'd9,
    A_STA_HI  = 4'd10,
    A_FLT_LO  = 4'd11,
    A_FLT_HI  = 4'd12,
    A_MGMT    = 4'd13
  } reg_addr_e;

  // status flag positions
  localparam int S_TXDONE = 0;
  localparam int S_RXDONE = 1;
  localparam int S_ERR    = 2;
  localparam int S_CHAIN  = 3;
  localparam int S_MISSW  = 4;
  localparam int S_CRCW   = 8;
  localparam int S_FRMW   = 9;
  localparam int S_OVFW   = 10;
  localparam int S_MGMT   = 12;
  localparam int S_POLL   = 31;

  localparam logic [STAT_W-1:0] STAT_KEEP = 13'h171F;
  localparam logic [31:0]       CTRL_KEEP = 32'hFFFF_0D19;

  // next status: clear written ones, then let events win
  function automatic logic [STAT_W-1:0] stat_next(
    input logic [STAT_W-1:0] cur,
    input logic [STAT_W-1:0] clr,
    input logic [STAT_W-1:0] set
  );
    return ((cur & ~(clr & STAT_KEEP)) | set) & STAT_KEEP;
  endfunction

  // interrupt reduction
  function automatic logic irq_of(
    input logic [STAT_W-1:0] st,
    input logic [STAT_W-1:0] en
  );
    return |(st & en);
  endfunction
endpackage

// File: rtl/emac_wrap_cnt.sv
`timescale 1ns/1ps
module emac_wrap_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = '1;

  assign wrap = inc && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (inc) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/emac_err_cnts.sv
`timescale 1ns/1ps
module emac_err_cnts #(
  parameter int ERR_W  = 8,
  parameter int MISS_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           err_inc,   // 0 crc, 1 framing, 2 overflow
  input  logic                 miss_inc,
  output logic [3*ERR_W-1:0]   err_cnt,
  output logic [2:0]           err_wrap,
  output logic [MISS_W-1:0]    miss_cnt,
  output logic                 miss_wrap
);
  for (genvar g = 0; g < 3; g++) begin : g_err
    emac_wrap_cnt #(.W(ERR_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (err_inc[g]),
      .cnt  (err_cnt[g*ERR_W +: ERR_W]),
      .wrap (err_wrap[g])
    );
  end

  emac_wrap_cnt #(.W(MISS_W)) u_miss (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (miss_inc),
    .cnt  (miss_cnt),
    .wrap (miss_wrap)
  );
endmodule

// File: rtl/emac_evt_status.sv
`timescale 1ns/1ps
module emac_evt_status
  import emac_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set,
  input  logic [STAT_W-1:0] clr,
  input  logic              poll_req,
  output logic [STAT_W-1:0] status,
  output logic              poll_strobe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status      <= '0;
      poll_strobe <= 1'b0;
    end else begin
      status      <= stat_next(status, clr, set);
      poll_strobe <= poll_req;
    end
  end
endmodule

// File: rtl/emac_csr_bank.sv
`timescale 1ns/1ps
module emac_csr_bank
  import emac_csr_pkg::*;
#(
  parameter int          ADDR_W  = 4,
  parameter logic [31:0] ID_CODE = 32'h0005_FD02,
  parameter int          ERR_W   = 8,
  parameter int          MISS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              ev_tx_done,
  input  logic              ev_rx_done,
  input  logic              ev_err,
  input  logic              ev_tx_chain,
  input  logic              ev_crc_err,
  input  logic              ev_frame_err,
  input  logic              ev_ovf_err,
  input  logic              ev_missed,
  input  logic              ev_mgmt_done,
  input  logic [15:0]       mgmt_rd_data,
  output logic              irq,
  output logic              poll_strobe,
  output logic              mac_en,
  output logic              tx_en,
  output logic              rx_en,
  output logic              bcast_reject,
  output logic              full_duplex,
  output logic              promisc,
  output logic [7:0]        rx_ring_len,
  output logic [7:0]        tx_ring_len,
  output logic [31:0]       poll_rate,
  output logic [31:0]       tx_ring_base,
  output logic [31:0]       rx_ring_base,
  output logic [47:0]       station_addr,
  output logic [63:0]       mcast_filter,
  output logic [31:0]       mgmt_cmd,
  output logic              mgmt_go
);
  localparam int ERR_PACK = 3 * ERR_W;

  // address decode, one select per register
  logic [NREG-1:0] wsel;
  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign wsel[g] = bus_wr && (bus_addr == ADDR_W'(g));
  end

  // counters
  logic [ERR_PACK-1:0] err_cnt;
  logic [2:0]          err_wrap;
  logic [MISS_W-1:0]   miss_cnt;
  logic                miss_wrap;

  emac_err_cnts #(.ERR_W(ERR_W), .MISS_W(MISS_W)) u_cnts (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_inc  ({ev_ovf_err, ev_frame_err, ev_crc_err}),
    .miss_inc (ev_missed),
    .err_cnt  (err_cnt),
    .err_wrap (err_wrap),
    .miss_cnt (miss_cnt),
    .miss_wrap(miss_wrap)
  );

  // event vector and clear mask, named for the checker
  logic [STAT_W-1:0] evt_set;
  logic [STAT_W-1:0] evt_clr;
  logic              poll_req;
  logic [STAT_W-1:0] status_q;

  always_comb begin
    evt_set           = '0;
    evt_set[S_TXDONE] = ev_tx_done;
    evt_set[S_RXDONE] = ev_rx_done;
    evt_set[S_ERR]    = ev_err;
    evt_set[S_CHAIN]  = ev_tx_chain;
    evt_set[S_MISSW]  = miss_wrap;
    evt_set[S_CRCW]   = err_wrap[0];
    evt_set[S_FRMW]   = err_wrap[1];
    evt_set[S_OVFW]   = err_wrap[2];
    evt_set[S_MGMT]   = ev_mgmt_done;
  end

  assign evt_clr  = wsel[A_STAT] ? bus_wdata[STAT_W-1:0] : '0;
  assign poll_req = wsel[A_STAT] && bus_wdata[S_POLL];

  emac_evt_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .set        (evt_set),
    .clr        (evt_clr),
    .poll_req   (poll_req),
    .status     (status_q),
    .poll_strobe(poll_strobe)
  );

  // plain storage registers
  logic [STAT_W-1:0] ien_q;
  logic [31:0]       ctrl_q, poll_q, txb_q, rxb_q, sta_lo_q, flt_lo_q, flt_hi_q, mgmt_q;
  logic [15:0]       sta_hi_q;
  logic              mgmt_go_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q     <= '0;
      ctrl_q    <= '0;
      poll_q    <= '0;
      txb_q     <= '0;
      rxb_q     <= '0;
      sta_lo_q  <= '0;
      sta_hi_q  <= '0;
      flt_lo_q  <= '0;
      flt_hi_q  <= '0;
      mgmt_q    <= '0;
      mgmt_go_q <= 1'b0;
    end else begin
      mgmt_go_q <= wsel[A_MGMT];
      if (wsel[A_IEN])    ien_q    <= bus_wdata[STAT_W-1:0] & STAT_KEEP;
      if (wsel[A_CTRL])   ctrl_q   <= bus_wdata & CTRL_KEEP;
      if (wsel[A_POLL])   poll_q   <= bus_wdata;
      if (wsel[A_TXBASE]) txb_q    <= bus_wdata;
      if (wsel[A_RXBASE]) rxb_q    <= bus_wdata;
      if (wsel[A_STA_LO]) sta_lo_q <= bus_wdata;
      if (wsel[A_STA_HI]) sta_hi_q <= bus_wdata[15:0];
      if (wsel[A_FLT_LO]) flt_lo_q <= bus_wdata;
      if (wsel[A_FLT_HI]) flt_hi_q <= bus_wdata;
      if (wsel[A_MGMT])       mgmt_q        <= bus_wdata;
      else if (ev_mgmt_done)  mgmt_q[15:0]  <= mgmt_rd_data;
    end
  end

  // read mux and registered return
  logic [31:0] rd_word;
  always_comb begin
    case (bus_addr)
      ADDR_W'(A_IDENT):   rd_word = ID_CODE;
      ADDR_W'(A_STAT):    rd_word = 32'(status_q);
      ADDR_W'(A_IEN):     rd_word = 32'(ien_q);
      ADDR_W'(A_CTRL):    rd_word = ctrl_q;
      ADDR_W'(A_POLL):    rd_word = poll_q;
      ADDR_W'(A_ERRCNT):  rd_word = 32'(err_cnt);
      ADDR_W'(A_MISSCNT): rd_word = 32'(miss_cnt);
      ADDR_W'(A_TXBASE):  rd_word = txb_q;
      ADDR_W'(A_RXBASE):  rd_word = rxb_q;
      ADDR_W'(A_STA_LO):  rd_word = sta_lo_q;
      ADDR_W'(A_STA_HI):  rd_word = 32'(sta_hi_q);
      ADDR_W'(A_FLT_LO):  rd_word = flt_lo_q;
      ADDR_W'(A_FLT_HI):  rd_word = flt_hi_q;
      ADDR_W'(A_MGMT):    rd_word = mgmt_q;
      default:            rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_word;
    end
  end

  // exported fields
  assign irq          = irq_of(status_q, ien_q);
  assign mac_en       = ctrl_q[0];
  assign tx_en        = ctrl_q[3];
  assign rx_en        = ctrl_q[4];
  assign bcast_reject = ctrl_q[8];
  assign full_duplex  = ctrl_q[10];
  assign promisc      = ctrl_q[11];
  assign tx_ring_len  = ctrl_q[23:16];
  assign rx_ring_len  = ctrl_q[31:24];
  assign poll_rate    = poll_q;
  assign tx_ring_base = txb_q;
  assign rx_ring_base = rxb_q;
  assign station_addr = {sta_hi_q, sta_lo_q};
  assign mcast_filter = {flt_hi_q, flt_lo_q};
  assign mgmt_cmd     = mgmt_q;
  assign mgmt_go      = mgmt_go_q;
endmodule

// File: rtl/emac_csr_chk.sv
`timescale 1ns/1ps
module emac_csr_chk
  import emac_csr_pkg::*;
#(
  parameter int          ADDR_W  = 4,
  parameter logic [31:0] ID_CODE = 32'h0005_FD02,
  parameter int          ERR_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic [STAT_W-1:0] evt_set,
  input logic [STAT_W-1:0] status_q,
  input logic [STAT_W-1:0] ien_q,
  input logic              irq,
  input logic              poll_strobe,
  input logic              ev_tx_done,
  input logic              ev_crc_err,
  input logic [ERR_W-1:0]  crc_cnt
);
  localparam logic [ERR_W-1:0] CNT_TOP = '1;

  assert_id_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(A_IDENT)) |=> (bus_rdata == ID_CODE));

  assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(A_STAT) && bus_wdata[S_TXDONE] && !ev_tx_done)
      |=> !status_q[S_TXDONE]);

  assert_evt_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((status_q & $past(evt_set)) == $past(evt_set)));

  assert_poll_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_strobe |-> $past(bus_wr && bus_addr == ADDR_W'(A_STAT) && bus_wdata[S_POLL]));

  assert_irq_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q != '0));

  assert_crc_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_crc_err && crc_cnt == CNT_TOP) |=> (status_q[S_CRCW] && crc_cnt == '0));
endmodule

bind emac_csr_bank emac_csr_chk #(
  .ADDR_W (ADDR_W),
  .ID_CODE(ID_CODE),
  .ERR_W  (ERR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .evt_set    (evt_set),
  .status_q   (status_q),
  .ien_q      (ien_q),
  .irq        (irq),
  .poll_strobe(poll_strobe),
  .ev_tx_done (ev_tx_done),
  .ev_crc_err (ev_crc_err),
  .crc_cnt    (err_cnt[ERR_W-1:0])
);

// File: tb/emac_csr_bank_tb.sv
`timescale 1ns/1ps
module emac_csr_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [8:0]  ev = '0;   // 0 tx,1 rx,2 err,3 chain,4 crc,5 frm,6 ovf,7 miss,8 mgmt
  logic [15:0] mgmt_rd_data = '0;
  logic        irq, poll_strobe, mac_en, tx_en, rx_en, bcast_reject, full_duplex, promisc;
  logic [7:0]  rx_ring_len, tx_ring_len;
  logic [31:0] poll_rate, tx_ring_base, rx_ring_base, mgmt_cmd;
  logic [47:0] station_addr;
  logic [63:0] mcast_filter;
  logic        mgmt_go;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  emac_csr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ev_tx_done(ev[0]), .ev_rx_done(ev[1]), .ev_err(ev[2]), .ev_tx_chain(ev[3]),
    .ev_crc_err(ev[4]), .ev_frame_err(ev[5]), .ev_ovf_err(ev[6]), .ev_missed(ev[7]),
    .ev_mgmt_done(ev[8]), .mgmt_rd_data(mgmt_rd_data),
    .irq(irq), .poll_strobe(poll_strobe), .mac_en(mac_en), .tx_en(tx_en), .rx_en(rx_en),
    .bcast_reject(bcast_reject), .full_duplex(full_duplex), .promisc(promisc),
    .rx_ring_len(rx_ring_len), .tx_ring_len(tx_ring_len), .poll_rate(poll_rate),
    .tx_ring_base(tx_ring_base), .rx_ring_base(rx_ring_base), .station_addr(station_addr),
    .mcast_filter(mcast_filter), .mgmt_cmd(mgmt_cmd), .mgmt_go(mgmt_go)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  task automatic check(input logic [63:0] got, input logic [63:0] exp, input string tag);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // monitor: pops scoreboard on each returned read
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (sb_q.size() == 0) begin
        nchk++; nerr++;
        $display("FAIL R2: unexpected read data 0x%0h expected none", bus_rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(64'(bus_rdata), 64'(it.exp), it.tag);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = 4'(a);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [8:0] m, input int n);
    ev = m;
    repeat (n) @(negedge clk);
    ev = '0;
  endtask

  initial begin
    #(200000 * 8);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check(64'(irq), 0, "R8 irq after reset");
    check(64'(mac_en), 0, "R3 enable after reset");
    check(64'(bus_rvalid), 0, "R2 idle rvalid");
    rd(0, 32'h0005_FD02, "R1 id value");
    rd(1, 32'h0, "R4 status after reset");

    // R1: id is read-only
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h0005_FD02, "R1 id after write");

    // R3: control fields
    wr(3, 32'hFFFF_FFFF);
    rd(3, 32'hFFFF_0D19, "R3 control writable mask");
    check({mac_en, tx_en, rx_en, bcast_reject, full_duplex, promisc}, 6'h3F, "R3 flag outputs");
    check({rx_ring_len, tx_ring_len}, 16'hFFFF, "R3 ring lengths");
    wr(3, 32'h1001_0019);
    rd(3, 32'h1001_0019, "R3 control readback");
    check({rx_ring_len, tx_ring_len}, 16'h1001, "R3 ring lengths 16/1");
    check({mac_en, tx_en, rx_en, bcast_reject, full_duplex, promisc}, 6'h38, "R3 mixed flags");

    // R14: plain words
    wr(4, 32'h0000_007D);
    wr(7, 32'h0000_1000);
    wr(8, 32'h0000_2000);
    wr(11, 32'hA5A5_0001);
    wr(12, 32'h8000_5A5A);
    rd(4, 32'h0000_007D, "R14 poll rate");
    rd(7, 32'h0000_1000, "R14 tx base");
    rd(8, 32'h0000_2000, "R14 rx base");
    rd(12, 32'h8000_5A5A, "R14 filter high");
    check(64'(poll_rate), 64'h7D, "R14 poll_rate port");
    check({tx_ring_base, rx_ring_base}, 64'h0000_1000_0000_2000, "R14 base ports");
    check(mcast_filter, 64'h8000_5A5A_A5A5_0001, "R14 filter port");

    // R12: station address
    wr(9, 32'h4433_2211);
    wr(10, 32'hFFFF_6655);
    rd(10, 32'h0000_6655, "R12 high word");
    rd(9, 32'h4433_2211, "R12 low word");
    check(64'(station_addr), 64'h6655_4433_2211, "R12 station_addr port");

    // R4/R5/R8
    pulse(9'h001, 1);
    rd(1, 32'h1, "R4 tx done flag");
    pulse(9'h00C, 1);
    rd(1, 32'hD, "R4 err and chain flags");
    check(64'(irq), 0, "R8 irq masked");
    wr(2, 32'h4);
    check(64'(irq), 1, "R8 irq enabled");
    rd(2, 32'h4, "R8 enable readback");
    wr(1, 32'h4);
    check(64'(irq), 0, "R5 irq after clear");
    rd(1, 32'h9, "R5 selective clear");
    wr(1, 32'h9);
    rd(1, 32'h0, "R5 clear rest");

    // R6: event vs clear in same cycle
    pulse(9'h002, 1);
    rd(1, 32'h2, "R4 rx done flag");
    ev = 9'h002; bus_wr = 1'b1; bus_addr = 4'd1; bus_wdata = 32'h2;
    @(negedge clk);
    ev = '0; bus_wr = 1'b0;
    rd(1, 32'h2, "R6 event beats clear");
    wr(1, 32'h2);
    rd(1, 32'h0, "R5 clear after collision");

    // R7: demand poll
    check(64'(poll_strobe), 0, "R7 strobe idle");
    wr(1, 32'h8000_0000);
    check(64'(poll_strobe), 1, "R7 strobe raised");
    @(negedge clk);
    check(64'(poll_strobe), 0, "R7 strobe one cycle");
    rd(1, 32'h0, "R7 bit31 not stored");

    // R9: error counters
    pulse(9'h010, 3);
    rd(5, 32'h0000_0003, "R9 crc count");
    pulse(9'h040, 2);
    rd(5, 32'h0002_0003, "R9 overflow count");
    pulse(9'h020, 256);
    rd(5, 32'h0002_0003, "R9 framing wrapped to 0");
    rd(1, 32'h200, "R9 framing wrap flag");
    wr(5, 32'hFFFF_FFFF);
    rd(5, 32'h0002_0003, "R11 err counters ignore write");
    pulse(9'h010, 253);
    rd(5, 32'h0002_0000, "R9 crc wrapped");
    rd(1, 32'h300, "R9 crc wrap flag");
    wr(1, 32'h300);

    // R10: missed counter
    pulse(9'h080, 65535);
    rd(6, 32'h0000_FFFF, "R10 missed at max");
    rd(1, 32'h0, "R10 no flag before wrap");
    wr(6, 32'h0000_1234);
    rd(6, 32'h0000_FFFF, "R11 miss counter ignores write");
    pulse(9'h080, 1);
    rd(6, 32'h0, "R10 missed wrapped");
    rd(1, 32'h10, "R10 wrap flag");
    wr(2, 32'h10);
    check(64'(irq), 1, "R8 irq on missed wrap");
    wr(1, 32'h10);
    check(64'(irq), 0, "R8 irq cleared");

    // R13: management
    wr(13, 32'h6082_0000);
    check(64'(mgmt_go), 1, "R13 go pulse");
    check(64'(mgmt_cmd), 64'h6082_0000, "R13 command port");
    @(negedge clk);
    check(64'(mgmt_go), 0, "R13 go one cycle");
    mgmt_rd_data = 16'hBEEF;
    pulse(9'h100, 1);
    rd(13, 32'h6082_BEEF, "R13 result loaded");
    rd(1, 32'h1000, "R13 complete flag");
    wr(2, 32'h1000);
    check(64'(irq), 1, "R8 irq on management complete");

    repeat (3) @(negedge clk);
    check(64'(sb_q.size()), 0, "R2 all reads returned");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule